// File: doc/BRIEF.md
# Eight-Way Addressable Latch Decoder

This block keeps eight single-bit storage cells and exposes them as a parallel output bus. A 3-bit select value picks one cell. Two active-low controls, an enable and a clear, choose one of four operating modes. The modes are: update only the selected cell from a serial data bit, freeze all cells, steer the data bit to the selected output while zeroing the rest, or zero the whole bank.

The storage uses flip-flops that update on the rising clock edge, not transparent latches. Every output is registered. A companion flag reports a protocol misuse: the select value moved between two back-to-back cycles while the block was updating single cells. The select value should only change while the bank is frozen, because a multi-bit change during a write can hit the wrong cell.

Top module: `octal_addr_latch`

## Requirements
- R1: A synchronous active-high `rst` sampled on a rising edge drives `q` to all zeros and `addr_err` low after that edge, whatever the mode inputs are.
- R2: Write mode is `en_n`=0 with `clr_n`=1. Bit `q[sel]` takes `din` and the other seven bits keep their values.
- R3: Hold mode is `en_n`=1 with `clr_n`=1. All eight bits keep their values whatever `din` and `sel` are.
- R4: Demultiplexer mode is `en_n`=0 with `clr_n`=0. Bit `q[sel]` becomes `din` and the other seven bits become 0.
- R5: The pattern left by demultiplexer mode is stored. A following hold cycle keeps that one-hot or all-zero pattern on `q`.
- R6: Clear mode is `en_n`=1 with `clr_n`=0. All eight bits become 0 whatever `din` and `sel` are.
- R7: `addr_err` is high for the cycle after an edge only when write mode was sampled on that edge and on the edge before, with different `sel` values. Otherwise it is low.
- R8: Each result appears on the outputs after the rising edge that samples its inputs, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit |
| sel | input | 3 | Cell select |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low clear |
| q | output | 8 | Stored bits, q[i] is cell i |
| addr_err | output | 1 | Select changed during consecutive write cycles |

## Verification
Each result is due one edge after its inputs are sampled: `q` for every mode, and `addr_err` for the second of two write cycles. The bench drives inputs on the falling edge and waits for one rising edge. It then samples at the next falling edge, so each check sees exactly the one-cycle result. For the R8 check, the bench also samples on the falling edge just after the inputs change, which proves the outputs have not moved before the edge.

// File: rtl/octal_latch_pkg.sv
package octal_latch_pkg;
    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } op_mode_e;
endpackage

// File: rtl/octal_mode_dec.sv
module octal_mode_dec
    import octal_latch_pkg::*;
(
    input  logic     en_n,
    input  logic     clr_n,
    output op_mode_e mode
);
    always_comb begin
        unique case ({en_n, clr_n})
            2'b01:   mode = MODE_WRITE;
            2'b11:   mode = MODE_HOLD;
            2'b00:   mode = MODE_DEMUX;
            default: mode = MODE_CLEAR;
        endcase
    end
endmodule

// File: rtl/octal_sel_dec.sv
module octal_sel_dec #(
    parameter int ADDR_W = 3,
    localparam int NCELL = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] sel,
    output logic [NCELL-1:0]  hot
);
    for (genvar i = 0; i < NCELL; i++) begin : g_line
        assign hot[i] = (sel == ADDR_W'(i));
    end
endmodule

// File: rtl/octal_addr_guard.sv
module octal_addr_guard #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] sel,
    output logic              addr_err
);
    typedef struct packed {
        logic [ADDR_W-1:0] prev_sel;
        logic              prev_wr;
        logic              err;
    } guard_t;

    guard_t g_d, g_q;

    always_comb begin
        g_d.prev_sel = sel;
        g_d.prev_wr  = is_write;
        g_d.err      = is_write && g_q.prev_wr && (sel != g_q.prev_sel);
        if (rst) begin
            g_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        g_q <= g_d;
    end

    assign addr_err = g_q.err;

    // R7: a select change across two write cycles raises the flag
    p_flag_on_move_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && is_write && $past(is_write) && sel != $past(sel)) |=> addr_err);

    // R7: the flag only follows a write cycle
    p_flag_needs_write_r7: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> $past(is_write));
endmodule

// File: rtl/octal_addr_latch.sv
module octal_addr_latch
    import octal_latch_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     din,
    input  logic [ADDR_W-1:0]        sel,
    input  logic                     en_n,
    input  logic                     clr_n,
    output logic [(1<<ADDR_W)-1:0]   q,
    output logic                     addr_err
);
    localparam int NCELL = 1 << ADDR_W;

    typedef struct packed {
        logic [NCELL-1:0] bits;
    } bank_t;

    op_mode_e         mode;
    logic [NCELL-1:0] hot;
    bank_t            bank_d, bank_q;

    octal_mode_dec u_mode (
        .en_n  (en_n),
        .clr_n (clr_n),
        .mode  (mode)
    );

    octal_sel_dec #(.ADDR_W(ADDR_W)) u_sel (
        .sel (sel),
        .hot (hot)
    );

    octal_addr_guard #(.ADDR_W(ADDR_W)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .is_write (mode == MODE_WRITE),
        .sel      (sel),
        .addr_err (addr_err)
    );

    always_comb begin
        bank_d = bank_q;
        unique case (mode)
            MODE_WRITE: bank_d.bits = (bank_q.bits & ~hot) | (hot & {NCELL{din}});
            MODE_HOLD:  bank_d.bits = bank_q.bits;
            MODE_DEMUX: bank_d.bits = hot & {NCELL{din}};
            default:    bank_d.bits = '0;
        endcase
        if (rst) begin
            bank_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        bank_q <= bank_d;
    end

    assign q = bank_q.bits;

    // R1: reset empties the bank
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (q == '0) && !addr_err);

    // R2: only the selected cell may move in write mode
    p_write_others_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WRITE) |=> ((q & ~$past(hot)) == ($past(q) & ~$past(hot)))
                                 && ((|(q & $past(hot))) == $past(din)));

    // R3: hold freezes every cell
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD) |=> $stable(q));

    // R4: demultiplexer leaves at most one cell set, matching the data bit
    p_demux_single_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DEMUX) |=> ($countones(q) <= 1) && ((q != '0) == $past(din)));

    // R6: clear empties the bank
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CLEAR) |=> (q == '0));
endmodule

// File: tb/octal_addr_latch_test.sv
module octal_addr_latch_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [7:0] q;
    logic       addr_err;

    int total = 0;
    int bad = 0;

    // Bench-side expectation
    logic [7:0] m_q = 8'h00;
    logic       m_err = 1'b0;
    logic [2:0] m_psel = 3'd0;
    logic       m_pwr = 1'b0;

    always #4 clk = ~clk;

    octal_addr_latch uut (
        .clk(clk), .rst(rst), .din(din), .sel(sel),
        .en_n(en_n), .clr_n(clr_n), .q(q), .addr_err(addr_err)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge, pass one rising edge, return at the next falling edge.
    task automatic apply(input logic r, input logic e, input logic c,
                         input logic [2:0] s, input logic d);
        logic wr;
        rst = r; en_n = e; clr_n = c; sel = s; din = d;
        wr = (!e && c);
        if (r) begin
            m_q = 8'h00; m_err = 1'b0; m_pwr = 1'b0; m_psel = 3'd0;
        end else begin
            m_err = wr && m_pwr && (s != m_psel);
            m_pwr = wr; m_psel = s;
            case ({e, c})
                2'b01: m_q[s] = d;
                2'b11: ;
                2'b00: begin m_q = 8'h00; m_q[s] = d; end
                default: m_q = 8'h00;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        apply(1, 1, 1, 0, 0);
        check("R1 reset q", q, 8'h00);
        check("R1 reset err", {7'd0, addr_err}, 8'h00);
        apply(0, 0, 1, 5, 1);
        apply(0, 1, 1, 5, 1);
        check("R1 preload", q, 8'h20);
        apply(1, 0, 1, 2, 1);
        check("R1 reset over write", q, 8'h00);
    endtask

    task automatic t_write;
        apply(0, 0, 1, 0, 1); apply(0, 1, 1, 0, 1);
        apply(0, 0, 1, 7, 1); apply(0, 1, 1, 7, 1);
        apply(0, 0, 1, 3, 1); apply(0, 1, 1, 3, 1);
        check("R2 write ones", q, m_q);
        check("R2 write ones value", q, 8'h89);
        apply(0, 0, 1, 0, 0);
        check("R2 write zero bit0", q, 8'h88);
    endtask

    task automatic t_hold;
        apply(0, 1, 1, 2, 1);
        apply(0, 1, 1, 6, 0);
        apply(0, 1, 1, 7, 0);
        check("R3 hold ignores din/sel", q, 8'h88);
    endtask

    task automatic t_demux;
        apply(0, 0, 0, 4, 1);
        check("R4 demux one", q, 8'h10);
        apply(0, 0, 0, 1, 1);
        check("R4 demux moves", q, 8'h02);
        apply(0, 1, 1, 1, 0);
        check("R5 held after demux", q, 8'h02);
        apply(0, 0, 0, 6, 0);
        check("R4 demux zero", q, 8'h00);
        apply(0, 1, 1, 3, 1);
        check("R5 held zero after demux", q, 8'h00);
    endtask

    task automatic t_clear;
        apply(0, 0, 1, 2, 1); apply(0, 1, 1, 2, 1);
        apply(0, 0, 1, 6, 1); apply(0, 1, 1, 6, 1);
        check("R2 setup for clear", q, 8'h44);
        apply(0, 1, 0, 6, 1);
        check("R6 clear", q, 8'h00);
    endtask

    task automatic t_err;
        apply(0, 1, 1, 0, 0);
        apply(0, 0, 1, 0, 1);
        check("R7 first write no flag", {7'd0, addr_err}, 8'h00);
        apply(0, 0, 1, 3, 1);
        check("R7 flag on move", {7'd0, addr_err}, 8'h01);
        check("R7 model flag", {7'd0, addr_err}, {7'd0, m_err});
        apply(0, 0, 1, 3, 0);
        check("R7 same sel no flag", {7'd0, addr_err}, 8'h00);
        apply(0, 1, 1, 5, 0);
        apply(0, 0, 1, 1, 1);
        check("R7 change in hold no flag", {7'd0, addr_err}, 8'h00);
        apply(0, 0, 0, 2, 1);
        apply(0, 0, 0, 6, 1);
        check("R7 demux moves no flag", {7'd0, addr_err}, 8'h00);
        check("R4 state after err test", q, m_q);
    endtask

    task automatic t_timing;
        apply(0, 1, 0, 0, 0);
        rst = 0; en_n = 0; clr_n = 1; sel = 3'd2; din = 1;
        #1;
        check("R8 no change before edge", q, 8'h00);
        m_q[2] = 1'b1; m_pwr = 1'b1; m_psel = 3'd2; m_err = 1'b0;
        @(negedge clk);
        check("R8 change after edge", q, 8'h04);
        apply(0, 1, 1, 2, 0);
    endtask

    initial begin
        @(negedge clk);
        apply(1, 1, 1, 0, 0);
        apply(1, 1, 1, 0, 0);
        t_reset();
        t_write();
        t_hold();
        t_demux();
        t_clear();
        t_err();
        t_timing();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule